// File: doc/BRIEF.md
# Dithered 14-bit Pulse-Width Generator

This block drives one pulse-width modulated output with 14 bits of duty resolution. An 8-bit coarse value sets the high time of a base cycle of 256 clocks. A 6-bit fine value spreads up to 63 single-clock extra pulses over a frame of 64 base cycles. The extra pulses land on fixed base cycles that are evenly spaced, in the manner of a binary rate multiplier. Averaged over a frame, the duty equals (coarse + fine/64)/256. The waveform repeats every 64 base cycles.

Software writes both settings through plain write strobes into shadow registers. The values in use are replaced only when a frame ends, so every frame runs on one consistent pair of settings. An enable input pauses the block: the counters hold their position and the output is held low.

Top module: `pwm_brm`

## Requirements
- R1: A base cycle is 256 enabled clocks long, and the slot counter advances by one on every enabled clock. A frame is 64 base cycles, and the frame counter advances when slot 255 is processed.
- R2: The output is registered. In the clock after an enabled edge that processes slot s, the output is high when s is less than the active coarse value. A coarse value of 0 gives no coarse high time. A coarse value of 255 gives 255 high slots per base cycle.
- R3: Extra pulses occupy only slot 255 of a base cycle. Base cycle c, numbered 1 to 63, receives one when fine bit (5 - t) is set, where t is the number of trailing zero bits of c. Base cycle 0 never receives one. So fine bit 0 selects cycle 32 only, which puts the pulse at frame sample index 32*256+255 = 8447.
- R4: Each set fine bit k adds 2^k pulses per frame, so a frame has exactly 64*M + N high clocks for coarse value M and fine value N.
- R5: Writes go into shadow registers. The active values take the shadow contents only at the edge that processes slot 255 of base cycle 63. A write made during a frame does not change that frame.
- R6: While the enable is low, both counters hold, no settings are loaded, and the output is low from the next clock. When the enable returns, the frame continues from where it stopped, and its total high count is the same as for an unpaused frame.
- R7: Reset (rst_n low) drives the output low and clears both counters and both the shadow and the active registers. Without new writes, the frames after reset stay fully low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one slot per enabled cycle |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to clk |
| en | input | 1 | Run enable; low freezes the counters and holds the output low |
| coarse_we | input | 1 | Write strobe for the coarse shadow register |
| coarse_wdata | input | 8 | Coarse duty value M |
| fine_we | input | 1 | Write strobe for the fine shadow register |
| fine_wdata | input | 6 | Fine rate value N |
| pwm_o | output | 1 | Pulse-width modulated output |

## Verification
A slot counter that is off by one moves every coarse edge, and the bench sees it within the first base cycle as a clock-by-clock mismatch against its own model. A frame counter or decoder fault puts extra pulses on the wrong base cycle, or gives the wrong number of them. That shows up as a wrong sample index for the single pulse, or a wrong high total, no later than the end of the frame, 16384 clocks. A shadow register that is loaded early changes the high total of the very frame in which the write was made. A counter that keeps running while disabled makes the paused frame's total and the model disagree from the first clock after the pause.

// File: rtl/pwm_brm_pkg.sv
package pwm_brm_pkg;

  // Boundary markers produced by the time base
  typedef struct packed {
    logic last_slot;   // slot counter at its final value
    logic frame_end;   // final slot of the final base cycle
  } pwm_tick_t;

endpackage

// File: rtl/pwm_brm_timebase.sv
module pwm_brm_timebase
  import pwm_brm_pkg::*;
#(
  parameter int CW = 8,
  parameter int FW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  output logic [CW-1:0] slot_o,
  output logic [FW-1:0] frame_o,
  output pwm_tick_t     tick_o
);

  localparam logic [CW-1:0] SLOT_MAX  = {CW{1'b1}};
  localparam logic [FW-1:0] FRAME_MAX = {FW{1'b1}};

  logic [CW-1:0] slot_q, slot_d;
  logic [FW-1:0] frame_q, frame_d;

  always_comb begin
    tick_o.last_slot = (slot_q == SLOT_MAX);
    tick_o.frame_end = tick_o.last_slot && (frame_q == FRAME_MAX);
  end

  always_comb begin
    slot_d  = slot_q;
    frame_d = frame_q;
    if (en) begin
      slot_d = slot_q + 1'b1;
      if (tick_o.last_slot) begin
        frame_d = frame_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q  <= '0;
      frame_q <= '0;
    end else begin
      slot_q  <= slot_d;
      frame_q <= frame_d;
    end
  end

  assign slot_o  = slot_q;
  assign frame_o = frame_q;

endmodule

// File: rtl/pwm_brm_cfg.sv
module pwm_brm_cfg #(
  parameter int CW = 8,
  parameter int FW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          coarse_we,
  input  logic [CW-1:0] coarse_wdata,
  input  logic          fine_we,
  input  logic [FW-1:0] fine_wdata,
  input  logic          load_i,
  output logic [CW-1:0] duty_o,
  output logic [FW-1:0] fine_o
);

  logic [CW-1:0] coarse_sh_q, coarse_sh_d, coarse_act_q, coarse_act_d;
  logic [FW-1:0] fine_sh_q, fine_sh_d, fine_act_q, fine_act_d;

  always_comb begin
    coarse_sh_d  = coarse_we ? coarse_wdata : coarse_sh_q;
    fine_sh_d    = fine_we ? fine_wdata : fine_sh_q;
    // Active copies follow the shadow only at the frame boundary
    coarse_act_d = load_i ? coarse_sh_q : coarse_act_q;
    fine_act_d   = load_i ? fine_sh_q : fine_act_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      coarse_sh_q  <= '0;
      fine_sh_q    <= '0;
      coarse_act_q <= '0;
      fine_act_q   <= '0;
    end else begin
      coarse_sh_q  <= coarse_sh_d;
      fine_sh_q    <= fine_sh_d;
      coarse_act_q <= coarse_act_d;
      fine_act_q   <= fine_act_d;
    end
  end

  assign duty_o = coarse_act_q;
  assign fine_o = fine_act_q;

endmodule

// File: rtl/pwm_brm_dither.sv
module pwm_brm_dither #(
  parameter int FW = 6
) (
  input  logic [FW-1:0] frame_i,
  input  logic [FW-1:0] fine_i,
  output logic          insert_o
);

  // hit[k]: lowest set bit of the frame index is bit k
  logic [FW-1:0] hit;
  logic [FW-1:0] pick;

  for (genvar k = 0; k < FW; k++) begin : g_bit
    if (k == 0) begin : g_lsb
      assign hit[k] = frame_i[0];
    end else begin : g_upper
      assign hit[k] = frame_i[k] && (frame_i[k-1:0] == '0);
    end
    // Least significant fine bit serves the sparsest cycle set
    assign pick[k] = hit[k] && fine_i[FW-1-k];
  end

  assign insert_o = |pick;

endmodule

// File: rtl/pwm_brm.sv
module pwm_brm
  import pwm_brm_pkg::*;
#(
  parameter int CW = 8,
  parameter int FW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          coarse_we,
  input  logic [CW-1:0] coarse_wdata,
  input  logic          fine_we,
  input  logic [FW-1:0] fine_wdata,
  output logic          pwm_o
);

  logic [CW-1:0] slot_w;
  logic [FW-1:0] frame_w;
  pwm_tick_t     tick_w;
  logic [CW-1:0] duty_w;
  logic [FW-1:0] fine_w;
  logic          insert_w;
  logic          load_w;
  logic          last_slot_w;
  logic          frame_end_w;
  logic          pwm_d;
  logic          pwm_q;

  assign last_slot_w = tick_w.last_slot;
  assign frame_end_w = tick_w.frame_end;
  assign load_w      = en && frame_end_w;

  pwm_brm_timebase #(.CW(CW), .FW(FW)) u_timebase (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .slot_o  (slot_w),
    .frame_o (frame_w),
    .tick_o  (tick_w)
  );

  pwm_brm_cfg #(.CW(CW), .FW(FW)) u_cfg (
    .clk          (clk),
    .rst_n        (rst_n),
    .coarse_we    (coarse_we),
    .coarse_wdata (coarse_wdata),
    .fine_we      (fine_we),
    .fine_wdata   (fine_wdata),
    .load_i       (load_w),
    .duty_o       (duty_w),
    .fine_o       (fine_w)
  );

  pwm_brm_dither #(.FW(FW)) u_dither (
    .frame_i  (frame_w),
    .fine_i   (fine_w),
    .insert_o (insert_w)
  );

  always_comb begin
    pwm_d = 1'b0;
    if (en) begin
      pwm_d = (slot_w < duty_w) || (last_slot_w && insert_w);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwm_q <= 1'b0;
    end else begin
      pwm_q <= pwm_d;
    end
  end

  assign pwm_o = pwm_q;

endmodule

// File: rtl/pwm_brm_chk.sv
module pwm_brm_chk #(
  parameter int CW = 8,
  parameter int FW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en,
  input logic          pwm_o,
  input logic [CW-1:0] slot,
  input logic [FW-1:0] frame,
  input logic [CW-1:0] duty,
  input logic [FW-1:0] fine,
  input logic          last_slot,
  input logic          frame_end
);

  AST_SLOT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> slot == CW'($past(slot) + 1'b1)); // R1

  AST_FRAME_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (en && last_slot) |=> frame == FW'($past(frame) + 1'b1)); // R1

  AST_LOW_ABOVE_DUTY: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !last_slot && slot >= duty) |=> !pwm_o); // R2

  AST_CYCLE0_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (en && last_slot && frame == '0 && slot >= duty) |=> !pwm_o); // R3

  AST_HIGH_BELOW_DUTY: assert property (@(posedge clk) disable iff (!rst_n)
    (en && slot < duty) |=> pwm_o); // R2

  AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !(en && frame_end) |=> ($stable(duty) && $stable(fine))); // R5

  AST_DISABLED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !pwm_o); // R6

  AST_DISABLED_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(slot) && $stable(frame))); // R6

endmodule

bind pwm_brm pwm_brm_chk #(.CW(CW), .FW(FW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .en        (en),
  .pwm_o     (pwm_o),
  .slot      (slot_w),
  .frame     (frame_w),
  .duty      (duty_w),
  .fine      (fine_w),
  .last_slot (last_slot_w),
  .frame_end (frame_end_w)
);

// File: tb/pwm_brm_tb.sv
module pwm_brm_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic       coarse_we = 1'b0;
  logic [7:0] coarse_wdata = '0;
  logic       fine_we = 1'b0;
  logic [5:0] fine_wdata = '0;
  logic       pwm_o;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk; // 125 MHz

  pwm_brm u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .en           (en),
    .coarse_we    (coarse_we),
    .coarse_wdata (coarse_wdata),
    .fine_we      (fine_we),
    .fine_wdata   (fine_wdata),
    .pwm_o        (pwm_o)
  );

  // Cycle selection from the requirement text: trailing zeros of c pick fine bit 5-t
  function automatic logic sel_cycle(input logic [5:0] c, input logic [5:0] n);
    int t;
    if (c == 0) return 1'b0;
    t = 0;
    while (c[t] == 1'b0) t++;
    return n[5-t];
  endfunction

  // Reference model
  logic [7:0] m_slot, m_M, s_M;
  logic [5:0] m_frame, m_N, s_N;
  logic       exp_q, adv_q, wrap_q;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_slot <= '0; m_frame <= '0; m_M <= '0; m_N <= '0; s_M <= '0; s_N <= '0;
      exp_q <= 1'b0; adv_q <= 1'b0; wrap_q <= 1'b0;
    end else begin
      adv_q  <= en;
      wrap_q <= 1'b0;
      if (en) begin
        exp_q  <= (m_slot < m_M) || (m_slot == 8'd255 && sel_cycle(m_frame, m_N));
        m_slot <= m_slot + 1'b1;
        if (m_slot == 8'd255) begin
          m_frame <= m_frame + 1'b1;
          if (m_frame == 6'd63) begin
            m_M <= s_M; m_N <= s_N; wrap_q <= 1'b1;
          end
        end
      end else begin
        exp_q <= 1'b0;
      end
      if (coarse_we) s_M <= coarse_wdata;
      if (fine_we)   s_N <= fine_wdata;
    end
  end

  // Observation at the falling edge
  int  mism = 0, mism_act = 0, mism_exp = 0, mism_at = -1, sample_no = 0;
  int  fr_hi = 0, fr_idx = 0, fr_first = -1, fr_ra = -1, fr_rb = -1;
  int  last_hi = -1, last_first = -1, last_gap = -1, frames_done = 0;
  int  dis_hi = 0;
  logic prev_o = 1'b0;

  always @(negedge clk) begin
    if (!rst_n) begin
      fr_hi = 0; fr_idx = 0; fr_first = -1; fr_ra = -1; fr_rb = -1; prev_o = 1'b0;
    end else begin
      sample_no++;
      if (pwm_o !== exp_q) begin
        if (mism == 0) begin mism_act = int'(pwm_o); mism_exp = int'(exp_q); mism_at = sample_no; end
        mism++;
      end
      if (adv_q) begin
        if (pwm_o) begin
          fr_hi++;
          if (fr_first < 0) fr_first = fr_idx;
          if (!prev_o) begin
            if (fr_ra < 0) fr_ra = fr_idx;
            else if (fr_rb < 0) fr_rb = fr_idx;
          end
        end
        prev_o = pwm_o;
        fr_idx++;
        if (wrap_q) begin
          last_hi = fr_hi; last_first = fr_first;
          last_gap = (fr_ra >= 0 && fr_rb >= 0) ? fr_rb - fr_ra : -1;
          fr_hi = 0; fr_idx = 0; fr_first = -1; fr_ra = -1; fr_rb = -1;
          frames_done++;
        end
      end else begin
        if (pwm_o) dis_hi++;
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic write_cfg(input logic [7:0] m, input logic [5:0] n);
    @(negedge clk);
    coarse_we = 1'b1; coarse_wdata = m; fine_we = 1'b1; fine_wdata = n;
    @(negedge clk);
    coarse_we = 1'b0; fine_we = 1'b0;
  endtask

  task automatic wait_frame();
    int f = frames_done;
    wait (frames_done != f);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; en = 1'b0;
    repeat (4) @(negedge clk);
    check("R7 output low in reset", int'(pwm_o), 0);
    rst_n = 1'b1; en = 1'b1;
  endtask

  task automatic t_shadow_hold();
    repeat (500) @(negedge clk);
    write_cfg(8'd64, 6'd0);
    wait_frame();
    check("R5 frame after reset ignores mid-frame write", last_hi, 0);
  endtask

  task automatic t_coarse();
    repeat (1000) @(negedge clk);
    write_cfg(8'd0, 6'd1);
    wait_frame();
    check("R2 coarse 64 high total", last_hi, 64 * 64);
    check("R5 fine write did not reach running frame", last_hi, 4096);
    check("R1 base cycle spacing of rising edges", last_gap, 256);
    check("R2 first high at slot 0", last_first, 0);
  endtask

  task automatic t_single();
    repeat (700) @(negedge clk);
    write_cfg(8'd255, 6'd63);
    wait_frame();
    check("R4 fine bit 0 adds one pulse", last_hi, 1);
    check("R3 pulse in slot 255 of cycle 32", last_first, 32 * 256 + 255);
  endtask

  task automatic t_full();
    repeat (300) @(negedge clk);
    write_cfg(8'd128, 6'h22);
    wait_frame();
    check("R4 coarse 255 fine 63 total", last_hi, 255 * 64 + 63);
  endtask

  task automatic t_enable();
    repeat (3000) @(negedge clk);
    dis_hi = 0;
    en = 1'b0;
    repeat (200) @(negedge clk);
    check("R6 output low while disabled", dis_hi, 0);
    en = 1'b1;
    wait_frame();
    check("R6 paused frame total for coarse 128 fine 0x22", last_hi, 128 * 64 + 34);
    check("R4 fine bits 1 and 5 give 34 pulses", last_hi - 128 * 64, 34);
  endtask

  task automatic t_reset_clear();
    repeat (100) @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R7 output low during mid-run reset", int'(pwm_o), 0);
    rst_n = 1'b1;
    wait_frame();
    check("R7 active settings cleared", last_hi, 0);
    wait_frame();
    check("R7 shadow settings cleared", last_hi, 0);
  endtask

  initial begin
    t_reset();
    t_shadow_hold();
    t_coarse();
    t_single();
    t_full();
    t_enable();
    t_reset_clear();
    n_chk++;
    if (mism != 0) begin
      n_bad++;
      $display("FAIL R2/R3 per-clock output at sample %0d: actual %0d expected %0d (%0d mismatches)",
               mism_at, mism_act, mism_exp, mism);
    end
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule